// File: doc/BRIEF.md
# Cache Victim Way Allocator with Lockdown

This block chooses the way that receives each line fill in a set-associative data cache. The cache has 32 sets of 32 ways, and each line is 32 bytes. Software can pin lines into the cache so that part of it behaves as fixed scratch memory. For every set the block keeps two values. The first is the number of pinned ways, which always form a contiguous region starting at way 0. The second is a round-robin pointer that only walks the ways above that region.

When the pin-mode input is high, each fill that misses is placed in the next free pinned way of its set and is reported as pinned. A request that hits allocates nothing. Once a set holds the maximum number of pinned ways, a further pinned fill falls back to an ordinary fill and raises an overflow flag. A release command clears the pin state of every set in one cycle. Each decision appears on the outputs one clock after its request.

Top module: `cway_alloc`

## Requirements
- R1: After reset, no grant is presented, and the first fill into any set receives way 0, whether the fill is normal or pinned.
- R2: A grant (`vic_valid`=1) appears exactly one cycle after a request with `req_valid`=1 and `req_hit`=0. A request with `req_hit`=1 produces no grant and leaves the set's state unchanged.
- R3: A fill with `lock_mode`=1 in a set holding k<28 pinned ways is granted way k with `vic_locked`=1, and that set then holds k+1 pinned ways.
- R4: A normal fill is granted the way held by the set's pointer, and the pointer then advances by one. From way 31 the pointer wraps to the lowest unpinned way of the set.
- R5: After a pinned fill, a pointer that would fall inside the pinned region is moved to the first way above it. A pointer already above the region stays where it is.
- R6: Each set keeps its own pin count and its own pointer, and traffic to one set never changes the grants of another set.
- R7: A fill with `lock_mode`=1 in a set already holding 28 pinned ways is handled as a normal fill (R4), with `vic_locked`=0 and `vic_ovf`=1. The pin count never exceeds 28.
- R8: `unlock`=1 clears the pin count and the pointer of every set to 0 in one cycle. A request in the same cycle as `unlock` is dropped and produces no grant.
- R9: A normal fill is never granted a way inside the set's pinned region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A fill request is present |
| req_set | input | 5 | Set index of the request address |
| req_hit | input | 1 | The request hit a line already in the cache |
| lock_mode | input | 1 | New fills are to be pinned |
| unlock | input | 1 | Release the pinned lines of all sets |
| vic_valid | output | 1 | A grant is presented |
| vic_way | output | 5 | Granted way |
| vic_locked | output | 1 | The granted way has been pinned |
| vic_ovf | output | 1 | A pinned fill overflowed and was made a normal fill |

## Verification
The hardest case to reach is the overflow. It requires 28 pinned fills into a single set, followed by further pinned fills that must land above the pinned region, plus a pointer that has gone all the way round so its wrap to the first unpinned way can be observed. Directed loops reach these cases by hammering one set. The bench computes the expected ways from the requirement arithmetic. A walked vector table covers the earlier cases: mixed pinned and normal fills, hits, set independence and release.

// File: rtl/cway_pkg.sv
package cway_pkg;

  // Pointer step over the unpinned range [cnt, ways-1]
  function automatic int rr_advance(int rr, int cnt, int ways);
    return (rr >= ways - 1) ? cnt : rr + 1;
  endfunction

  // Pointer after the pinned region grows to new_cnt ways
  function automatic int rr_after_pin(int rr, int new_cnt);
    return (rr < new_cnt) ? new_cnt : rr;
  endfunction

endpackage

// File: rtl/cway_set_state.sv
module cway_set_state #(
  parameter int WAY_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [WAY_W-1:0] nxt_cnt,
  input  logic [WAY_W-1:0] nxt_rr,
  output logic [WAY_W-1:0] cnt,
  output logic [WAY_W-1:0] rr
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
      rr  <= '0;
    end else if (wr_en) begin
      cnt <= nxt_cnt;
      rr  <= nxt_rr;
    end
  end

endmodule

// File: rtl/cway_pick.sv
module cway_pick
  import cway_pkg::*;
#(
  parameter int NUM_WAYS = 32,
  parameter int MAX_LOCK = 28,
  parameter int WAY_W    = 5
) (
  input  logic             lock_mode,
  input  logic [WAY_W-1:0] cur_cnt,
  input  logic [WAY_W-1:0] cur_rr,
  output logic [WAY_W-1:0] way,
  output logic             pin,
  output logic             ovf,
  output logic [WAY_W-1:0] nxt_cnt,
  output logic [WAY_W-1:0] nxt_rr
);

  logic room;
  assign room = int'(cur_cnt) < MAX_LOCK;

  always_comb begin
    pin = lock_mode && room;
    ovf = lock_mode && !room;
    if (pin) begin
      way     = cur_cnt;
      nxt_cnt = cur_cnt + WAY_W'(1);
      nxt_rr  = WAY_W'(rr_after_pin(int'(cur_rr), int'(cur_cnt) + 1));
    end else begin
      way     = cur_rr;
      nxt_cnt = cur_cnt;
      nxt_rr  = WAY_W'(rr_advance(int'(cur_rr), int'(cur_cnt), NUM_WAYS));
    end
  end

endmodule

// File: rtl/cway_alloc.sv
module cway_alloc #(
  parameter int NUM_SETS = 32,
  parameter int NUM_WAYS = 32,
  parameter int MAX_LOCK = 28,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [SET_W-1:0] req_set,
  input  logic             req_hit,
  input  logic             lock_mode,
  input  logic             unlock,
  output logic             vic_valid,
  output logic [WAY_W-1:0] vic_way,
  output logic             vic_locked,
  output logic             vic_ovf
);

  logic [WAY_W-1:0] cnt_arr [NUM_SETS];
  logic [WAY_W-1:0] rr_arr  [NUM_SETS];

  // Named internal events for the checker
  logic             fill_ev;
  logic             pin_ev;
  logic             ovf_ev;
  logic [WAY_W-1:0] cur_cnt;
  logic [WAY_W-1:0] cur_rr;
  logic [WAY_W-1:0] pick_way;
  logic [WAY_W-1:0] nxt_cnt;
  logic [WAY_W-1:0] nxt_rr;

  assign fill_ev = req_valid && !req_hit && !unlock;
  assign cur_cnt = cnt_arr[req_set];
  assign cur_rr  = rr_arr[req_set];

  cway_pick #(
    .NUM_WAYS(NUM_WAYS),
    .MAX_LOCK(MAX_LOCK),
    .WAY_W   (WAY_W)
  ) u_pick (
    .lock_mode(lock_mode),
    .cur_cnt  (cur_cnt),
    .cur_rr   (cur_rr),
    .way      (pick_way),
    .pin      (pin_ev),
    .ovf      (ovf_ev),
    .nxt_cnt  (nxt_cnt),
    .nxt_rr   (nxt_rr)
  );

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic hit_this;
    assign hit_this = fill_ev && (int'(req_set) == s);
    cway_set_state #(.WAY_W(WAY_W)) u_state (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (unlock),
      .wr_en  (hit_this),
      .nxt_cnt(nxt_cnt),
      .nxt_rr (nxt_rr),
      .cnt    (cnt_arr[s]),
      .rr     (rr_arr[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vic_valid  <= 1'b0;
      vic_way    <= '0;
      vic_locked <= 1'b0;
      vic_ovf    <= 1'b0;
    end else begin
      vic_valid  <= fill_ev;
      vic_way    <= fill_ev ? pick_way : '0;
      vic_locked <= fill_ev && pin_ev;
      vic_ovf    <= fill_ev && ovf_ev;
    end
  end

endmodule

// File: rtl/cway_alloc_chk.sv
module cway_alloc_chk #(
  parameter int MAX_LOCK = 28,
  parameter int SET_W    = 5,
  parameter int WAY_W    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_hit,
  input logic             unlock,
  input logic             vic_valid,
  input logic [WAY_W-1:0] vic_way,
  input logic             vic_locked,
  input logic             vic_ovf,
  input logic [WAY_W-1:0] cur_cnt,
  input logic [WAY_W-1:0] cur_rr
);

  assert_hit_no_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_hit && !unlock) |=> !vic_valid);

  assert_pin_way_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && vic_locked) |-> (vic_way == $past(cur_cnt)));

  assert_ptr_above_region_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cur_rr >= cur_cnt);

  assert_ovf_is_normal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vic_ovf |-> (vic_valid && !vic_locked));

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cur_cnt) <= MAX_LOCK);

  assert_unlock_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |=> (!vic_valid && cur_cnt == '0 && cur_rr == '0));

  assert_victim_unpinned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && !vic_locked) |-> (vic_way >= $past(cur_cnt)));

endmodule

bind cway_alloc cway_alloc_chk #(
  .MAX_LOCK(MAX_LOCK),
  .SET_W   (SET_W),
  .WAY_W   (WAY_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_hit   (req_hit),
  .unlock    (unlock),
  .vic_valid (vic_valid),
  .vic_way   (vic_way),
  .vic_locked(vic_locked),
  .vic_ovf   (vic_ovf),
  .cur_cnt   (cur_cnt),
  .cur_rr    (cur_rr)
);

// File: tb/tb_cway_alloc.sv
`timescale 1ns/100ps
module tb_cway_alloc;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [4:0] req_set;
  logic       req_hit;
  logic       lock_mode;
  logic       unlock;
  logic       vic_valid;
  logic [4:0] vic_way;
  logic       vic_locked;
  logic       vic_ovf;

  int  nvec  = 0;
  int  nfail = 0;
  bit  done  = 1'b0;

  always #2.5 clk = ~clk;

  cway_alloc dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_set(req_set),
    .req_hit(req_hit), .lock_mode(lock_mode), .unlock(unlock),
    .vic_valid(vic_valid), .vic_way(vic_way), .vic_locked(vic_locked),
    .vic_ovf(vic_ovf)
  );

  // {valid, set, hit, lock, unlock, exp_valid, exp_way, exp_locked, exp_ovf}
  localparam int NV = 15;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 5'd3, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0, 1'b0, 1'b0}, // R1 R4
    {1'b1, 5'd3, 1'b0, 1'b0, 1'b0, 1'b1, 5'd1, 1'b0, 1'b0}, // R4
    {1'b1, 5'd3, 1'b0, 1'b1, 1'b0, 1'b1, 5'd0, 1'b1, 1'b0}, // R3
    {1'b1, 5'd3, 1'b0, 1'b1, 1'b0, 1'b1, 5'd1, 1'b1, 1'b0}, // R3
    {1'b1, 5'd3, 1'b0, 1'b1, 1'b0, 1'b1, 5'd2, 1'b1, 1'b0}, // R3 R5
    {1'b1, 5'd3, 1'b0, 1'b0, 1'b0, 1'b1, 5'd3, 1'b0, 1'b0}, // R5 R9
    {1'b1, 5'd3, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0}, // R2 hit
    {1'b1, 5'd3, 1'b0, 1'b0, 1'b0, 1'b1, 5'd4, 1'b0, 1'b0}, // R2 state kept
    {1'b1, 5'd7, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0, 1'b0, 1'b0}, // R6
    {1'b1, 5'd7, 1'b0, 1'b1, 1'b0, 1'b1, 5'd0, 1'b1, 1'b0}, // R6 R3
    {1'b1, 5'd7, 1'b0, 1'b0, 1'b0, 1'b1, 5'd1, 1'b0, 1'b0}, // R5
    {1'b1, 5'd3, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0}, // R8 dropped
    {1'b1, 5'd3, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0, 1'b0, 1'b0}, // R8 cleared
    {1'b1, 5'd3, 1'b0, 1'b1, 1'b0, 1'b1, 5'd0, 1'b1, 1'b0}, // R8 pin restart
    {1'b1, 5'd3, 1'b0, 1'b0, 1'b0, 1'b1, 5'd1, 1'b0, 1'b0}  // R5
  };

  task automatic step(input logic v, input logic [4:0] s, input logic h,
                      input logic l, input logic u);
    req_valid = v; req_set = s; req_hit = h; lock_mode = l; unlock = u;
    @(negedge clk);
    req_valid = 1'b0; req_hit = 1'b0; lock_mode = 1'b0; unlock = 1'b0;
  endtask

  task automatic check(input string req, input logic ev, input logic [4:0] ew,
                       input logic el, input logic eo);
    nvec++;
    if (vic_valid !== ev || (ev && vic_way !== ew) ||
        vic_locked !== el || vic_ovf !== eo) begin
      nfail++;
      $display("FAIL %s: got valid=%0b way=%0d locked=%0b ovf=%0b, expected valid=%0b way=%0d locked=%0b ovf=%0b",
               req, vic_valid, vic_way, vic_locked, vic_ovf, ev, ew, el, eo);
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_set = '0; req_hit = 1'b0;
    lock_mode = 1'b0; unlock = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 5'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][16], VEC[i][15:11], VEC[i][10], VEC[i][9], VEC[i][8]);
      check($sformatf("table row %0d", i), VEC[i][7], VEC[i][6:2], VEC[i][1], VEC[i][0]);
    end

    // R4 R5: two pinned ways in set 10, then the pointer walks 2..31 and wraps to 2
    for (int k = 0; k < 2; k++) begin
      step(1'b1, 5'd10, 1'b0, 1'b1, 1'b0);
      check("R3 set10 pin", 1'b1, 5'(k), 1'b1, 1'b0);
    end
    for (int w = 2; w < 32; w++) begin
      step(1'b1, 5'd10, 1'b0, 1'b0, 1'b0);
      check("R4 set10 walk", 1'b1, 5'(w), 1'b0, 1'b0);
    end
    step(1'b1, 5'd10, 1'b0, 1'b0, 1'b0);
    check("R4 R9 wrap to first unpinned", 1'b1, 5'd2, 1'b0, 1'b0);

    // R7: fill set 20 up to the limit, then overflow
    for (int k = 0; k < 28; k++) begin
      step(1'b1, 5'd20, 1'b0, 1'b1, 1'b0);
      check("R3 set20 pin", 1'b1, 5'(k), 1'b1, 1'b0);
    end
    step(1'b1, 5'd20, 1'b0, 1'b1, 1'b0);
    check("R7 overflow", 1'b1, 5'd28, 1'b0, 1'b1);
    step(1'b1, 5'd20, 1'b0, 1'b0, 1'b0);
    check("R7 normal after overflow", 1'b1, 5'd29, 1'b0, 1'b0);
    step(1'b1, 5'd20, 1'b0, 1'b1, 1'b0);
    check("R7 second overflow", 1'b1, 5'd30, 1'b0, 1'b1);
    step(1'b1, 5'd20, 1'b0, 1'b0, 1'b0);
    check("R4 R9 set20", 1'b1, 5'd31, 1'b0, 1'b0);
    step(1'b1, 5'd20, 1'b0, 1'b0, 1'b0);
    check("R4 R9 set20 wrap to 28", 1'b1, 5'd28, 1'b0, 1'b0);

    // R6: set 10 unaffected by set 20 traffic
    step(1'b1, 5'd10, 1'b0, 1'b0, 1'b0);
    check("R6 set10 pointer kept", 1'b1, 5'd3, 1'b0, 1'b0);

    // R8: release with a same-cycle pinned request
    step(1'b1, 5'd20, 1'b0, 1'b1, 1'b1);
    check("R8 request dropped", 1'b0, 5'd0, 1'b0, 1'b0);
    step(1'b1, 5'd20, 1'b0, 1'b1, 1'b0);
    check("R8 set20 pin restarts", 1'b1, 5'd0, 1'b1, 1'b0);
    step(1'b1, 5'd10, 1'b0, 1'b0, 1'b0);
    check("R8 set10 pointer cleared", 1'b1, 5'd0, 1'b0, 1'b0);

    // R1: reset in the middle of a run
    rst_n = 1'b0;
    step(1'b1, 5'd20, 1'b0, 1'b0, 1'b0);
    check("R1 no grant in reset", 1'b0, 5'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    step(1'b1, 5'd20, 1'b0, 1'b0, 1'b0);
    check("R1 first fill after reset", 1'b1, 5'd0, 1'b0, 1'b0);
    step(1'b0, 5'd20, 1'b0, 1'b0, 1'b0);
    check("R2 idle no grant", 1'b0, 5'd0, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule